// File: doc/BRIEF.md
# Resolver Angle Capture Buffer

This block collects angle words from a resolver-to-digital converter that tracks the shaft angle continuously. The converter raises a busy line while it is tracking, and the angle bus moves during that time. When busy drops, the conversion is complete and the bus holds a settled value. The block treats every high-to-low transition of busy as one finished sample. It stores that sample in a small dual-clock queue, and host logic drains the queue from its own clock domain.

The sample side runs on `wrClk`. The busy line is asynchronous to it, so it passes through a two-stage synchronizer. The angle bus is taken one cycle after the synchronized falling edge is seen, while busy is still low. The host side runs on `rdClk` and supplies three controls: a read strobe, a capture-enable level and a clear level. The queue pointers cross between the two domains in Gray code. Full and a sticky overflow flag belong to the sample domain. Empty and a sticky underflow flag belong to the host domain.

Top module: `rdc_capture_fifo`

## Requirements
- R1: Each falling edge of `convBusy` that happens while capture is enabled stores exactly one word, equal to the `convData` value held stable while busy is low. Bus changes while busy is high, and a rising edge, store nothing.
- R2: Words leave in the order they were stored. `rdData` shows the next word on the `rdClk` edge that samples `rdStrobe` high while `rdEmpty` is 0, and it does not change on any other edge.
- R3: The queue holds 64 words. `wrFull` reads 1 once 64 words are stored and unread.
- R4: A falling edge that arrives while `wrFull` is 1 stores nothing and sets `wrOverflow` to 1. The flag stays set until a clear.
- R5: A read strobe while `rdEmpty` is 1 leaves `rdData` at the last word read and does not move the read position. It sets `rdUnderflow` to 1, and the flag stays set until a clear.
- R6: While `captureEn` is 0, falling edges of `convBusy` store nothing.
- R7: While `hostClear` is 1, both positions return to zero, both sticky flags drop, reads are ignored and busy edges store nothing. After release the queue is empty and reusable.
- R8: After reset, `rdEmpty`=1, `wrFull`=0, `wrOverflow`=0, `rdUnderflow`=0 and `rdData`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Sample-side clock |
| wrRstN | input | 1 | Sample-side asynchronous reset, active low |
| convBusy | input | 1 | Converter busy line; a falling edge marks a finished conversion |
| convData | input | 14 | Converter angle bus |
| rdClk | input | 1 | Host-side clock |
| rdRstN | input | 1 | Host-side asynchronous reset, active low |
| captureEn | input | 1 | Host level that allows samples to be stored |
| hostClear | input | 1 | Host level that empties the queue and drops both flags |
| rdStrobe | input | 1 | Host read request, one word per cycle high |
| rdData | output | 14 | Last word read from the queue |
| rdEmpty | output | 1 | Queue empty, host domain |
| rdUnderflow | output | 1 | Sticky flag for a read while empty, host domain |
| wrFull | output | 1 | Queue full, sample domain |
| wrOverflow | output | 1 | Sticky flag for a sample dropped while full, sample domain |

## Verification
The in-module assertions check five properties on every clock cycle:
- a dropped sample or an ignored read leaves the pointers unchanged and sets its sticky flag;
- the flags stay set until a clear;
- the Gray pointers move by at most one bit per edge;
- a clear holds the write position at zero;
- `rdData` changes only on an accepted read.

Other behaviours can only be shown by the bench's scenarios, because they depend on the converter waveform and on the order of words across both clock domains:
- the value stored for each busy fall, while the bus changes during busy-high;
- first-in first-out order across pointer wraparound;
- the exact 64-word capacity;
- edges ignored while capture is disabled or a clear is held.

// File: rtl/rdc_fifo_pkg.sv
package rdc_fifo_pkg;
  // Strobes from control to datapath, one per clock domain.
  typedef struct packed {
    logic push;  // sample domain: store convData at wrAddr
    logic pop;   // host domain: load rdData from rdAddr
  } fifoStrobe_t;
endpackage

// File: rtl/rdc_sync2.sv
module rdc_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rdc_fifo_ctrl.sv
module rdc_fifo_ctrl
  import rdc_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              convBusy,
  input  logic              captureEn,
  input  logic              hostClear,
  input  logic              rdStrobe,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrFull,
  output logic              wrOverflow,
  output logic              rdEmpty,
  output logic              rdUnderflow
);
  localparam int PTR_W = ADDR_W + 1;

  // ---------------- sample domain ----------------
  logic             busySync, enSync, clrSync, busyPrev, pushReq;
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, rdGrayAtWr;

  rdc_sync2 #(.WIDTH(1)) uBusySync (.clk(wrClk), .rstN(wrRstN), .d(convBusy),  .q(busySync));
  rdc_sync2 #(.WIDTH(1)) uEnSync   (.clk(wrClk), .rstN(wrRstN), .d(captureEn), .q(enSync));
  rdc_sync2 #(.WIDTH(1)) uClrSync  (.clk(wrClk), .rstN(wrRstN), .d(hostClear), .q(clrSync));
  rdc_sync2 #(.WIDTH(PTR_W)) uRdPtrSync (.clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGrayAtWr));

  assign wrBinNext = wrBin + 1'b1;
  assign wrFull    = (wrGray == {~rdGrayAtWr[PTR_W-1:PTR_W-2], rdGrayAtWr[PTR_W-3:0]});
  assign wrAddr    = wrBin[ADDR_W-1:0];
  assign strobe.push = pushReq & ~wrFull & ~clrSync;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      busyPrev   <= 1'b0;
      pushReq    <= 1'b0;
      wrBin      <= '0;
      wrGray     <= '0;
      wrOverflow <= 1'b0;
    end else begin
      busyPrev <= busySync;
      // Falling edge seen now; the word is taken on the following cycle.
      pushReq  <= busyPrev & ~busySync & enSync & ~clrSync;
      if (clrSync) begin
        wrBin      <= '0;
        wrGray     <= '0;
        wrOverflow <= 1'b0;
        pushReq    <= 1'b0;
      end else if (pushReq) begin
        if (wrFull) begin
          wrOverflow <= 1'b1;
        end else begin
          wrBin  <= wrBinNext;
          wrGray <= wrBinNext ^ (wrBinNext >> 1);
        end
      end
    end
  end

  // ---------------- host domain ----------------
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, wrGrayAtRd;

  rdc_sync2 #(.WIDTH(PTR_W)) uWrPtrSync (.clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGrayAtRd));

  assign rdBinNext  = rdBin + 1'b1;
  assign rdEmpty    = (rdGray == wrGrayAtRd);
  assign rdAddr     = rdBin[ADDR_W-1:0];
  assign strobe.pop = rdStrobe & ~rdEmpty & ~hostClear;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      rdUnderflow <= 1'b0;
    end else if (hostClear) begin
      rdBin       <= '0;
      rdGray      <= '0;
      rdUnderflow <= 1'b0;
    end else if (rdStrobe) begin
      if (rdEmpty) begin
        rdUnderflow <= 1'b1;
      end else begin
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
    end
  end

  // ---------------- assertions ----------------
  p_drop_when_full_r4: assert property (@(posedge wrClk) disable iff (!wrRstN || clrSync)
    (pushReq && wrFull) |=> ($stable(wrBin) && wrOverflow));

  p_overflow_sticky_r4: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrOverflow && !clrSync) |=> wrOverflow);

  p_clear_holds_wr_r7: assert property (@(posedge wrClk) disable iff (!wrRstN)
    clrSync |=> (wrBin == '0 && !wrOverflow));

  p_wr_gray_step_r2: assert property (@(posedge wrClk) disable iff (!wrRstN || clrSync)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  p_empty_read_r5: assert property (@(posedge rdClk) disable iff (!rdRstN || hostClear)
    (rdStrobe && rdEmpty) |=> ($stable(rdBin) && rdUnderflow));

  p_underflow_sticky_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdUnderflow && !hostClear) |=> rdUnderflow);

  p_rd_gray_step_r2: assert property (@(posedge rdClk) disable iff (!rdRstN || hostClear)
    $countones(rdGray ^ $past(rdGray)) <= 1);
endmodule

// File: rtl/rdc_fifo_datapath.sv
module rdc_fifo_datapath
  import rdc_fifo_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] convData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  // Busy has been low for several cycles by now, so the bus is settled.
  always_ff @(posedge wrClk) begin
    if (strobe.push) store[wrAddr] <= convData;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         rdData <= '0;
    else if (strobe.pop) rdData <= store[rdAddr];
  end

  p_rd_hold_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !strobe.pop |=> $stable(rdData));
endmodule

// File: rtl/rdc_capture_fifo.sv
module rdc_capture_fifo
  import rdc_fifo_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int DEPTH  = 64
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              convBusy,
  input  logic [DATA_W-1:0] convData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              captureEn,
  input  logic              hostClear,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic              rdUnderflow,
  output logic              wrFull,
  output logic              wrOverflow
);
  localparam int ADDR_W = $clog2(DEPTH);

  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  rdc_fifo_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .convBusy(convBusy), .captureEn(captureEn), .hostClear(hostClear),
    .rdStrobe(rdStrobe), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrFull(wrFull), .wrOverflow(wrOverflow), .rdEmpty(rdEmpty),
    .rdUnderflow(rdUnderflow)
  );

  rdc_fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .convData(convData), .rdData(rdData)
  );
endmodule

// File: tb/rdc_capture_fifo_test.sv
`timescale 1ns/1ps
module rdc_capture_fifo_test;
  localparam int DW = 14;
  localparam int DEPTH = 64;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic convBusy = 1, captureEn = 0, hostClear = 0, rdStrobe = 0;
  logic [DW-1:0] convData = '0;
  logic [DW-1:0] rdData;
  logic rdEmpty, rdUnderflow, wrFull, wrOverflow;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 wrClk = ~wrClk;  // 200 MHz sample clock
  always #3.5 rdClk = ~rdClk;  // host clock

  rdc_capture_fifo uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .convBusy(convBusy), .convData(convData),
    .rdClk(rdClk), .rdRstN(rdRstN), .captureEn(captureEn), .hostClear(hostClear),
    .rdStrobe(rdStrobe), .rdData(rdData), .rdEmpty(rdEmpty),
    .rdUnderflow(rdUnderflow), .wrFull(wrFull), .wrOverflow(wrOverflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One conversion: bus wanders while busy is high, then settles and busy falls.
  task automatic convert(input logic [DW-1:0] value);
    convBusy = 1;
    convData = ~value;
    #9 convData = value ^ 14'h0155;
    #9 convData = value;
    #4 convBusy = 0;
    #45;
  endtask

  task automatic hostRead(output logic [DW-1:0] got);
    @(negedge rdClk) rdStrobe = 1;
    @(negedge rdClk) rdStrobe = 0;
    got = rdData;
  endtask

  task automatic settle();
    repeat (10) @(negedge rdClk);
  endtask

  function automatic logic [DW-1:0] fillVal(input int i);
    return DW'((i * 517 + 11) % 16384);
  endfunction

  initial begin
    #150000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got;
    logic [DW-1:0] lastWord;
    #20 wrRstN = 1; rdRstN = 1;
    settle();
    // R8 reset state
    chk("R8 empty", rdEmpty, 1);
    chk("R8 full", wrFull, 0);
    chk("R8 overflow", wrOverflow, 0);
    chk("R8 underflow", rdUnderflow, 0);
    chk("R8 rdData", rdData, 0);

    // R6 capture disabled: edges ignored
    for (int i = 0; i < 3; i++) convert(DW'(i + 100));
    settle();
    chk("R6 empty while disabled", rdEmpty, 1);

    @(negedge rdClk) captureEn = 1;
    settle();
    // R1 rising edge and long high period store nothing
    convBusy = 1;
    convData = 14'h2AAA;
    #80;
    settle();
    chk("R1 busy high stores nothing", rdEmpty, 1);

    // R1/R2 short pattern sweep
    for (int i = 0; i < 5; i++) convert(DW'((i * 3277 + 7) % 16384));
    settle();
    chk("R1 not empty", rdEmpty, 0);
    for (int i = 0; i < 5; i++) begin
      hostRead(got);
      chk("R1 R2 word", got, (i * 3277 + 7) % 16384);
    end
    settle();
    chk("R2 empty after drain", rdEmpty, 1);

    // R3 capacity and R4 overflow
    for (int i = 0; i < DEPTH - 1; i++) convert(fillVal(i));
    settle();
    chk("R3 not full at 63", wrFull, 0);
    convert(fillVal(DEPTH - 1));
    settle();
    chk("R3 full at 64", wrFull, 1);
    chk("R4 no overflow yet", wrOverflow, 0);
    convert(14'h1234);
    settle();
    chk("R4 overflow set", wrOverflow, 1);
    chk("R4 still full", wrFull, 1);
    lastWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(got);
      chk("R2 R4 drained word", got, fillVal(i));
      lastWord = got;
    end
    settle();
    chk("R4 empty after 64 reads", rdEmpty, 1);
    chk("R4 overflow sticky", wrOverflow, 1);

    // R5 read while empty
    hostRead(got);
    chk("R5 rdData held", got, lastWord);
    settle();
    chk("R5 underflow set", rdUnderflow, 1);
    convert(14'h0ACE);
    settle();
    hostRead(got);
    chk("R5 pointer unmoved", got, 14'h0ACE);
    chk("R5 underflow sticky", rdUnderflow, 1);

    // R7 clear
    for (int i = 0; i < 3; i++) convert(DW'(i + 900));
    @(negedge rdClk) hostClear = 1;
    settle();
    convert(14'h0777);
    convert(14'h0888);
    @(negedge rdClk) rdStrobe = 1;
    @(negedge rdClk) rdStrobe = 0;
    chk("R7 read ignored in clear", rdData, 14'h0ACE);
    @(negedge rdClk) hostClear = 0;
    settle();
    chk("R7 empty after clear", rdEmpty, 1);
    chk("R7 overflow cleared", wrOverflow, 0);
    chk("R7 underflow cleared", rdUnderflow, 0);
    chk("R7 not full", wrFull, 0);
    convert(14'h3001);
    settle();
    hostRead(got);
    chk("R7 reuse after clear", got, 14'h3001);

    // R2 wraparound sweep
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 40; i++) convert(DW'((r * 40 + i) * 131 % 16384));
      settle();
      for (int i = 0; i < 40; i++) begin
        hostRead(got);
        chk("R2 wrap order", got, (r * 40 + i) * 131 % 16384);
      end
    end
    settle();
    chk("R2 empty end", rdEmpty, 1);
    chk("R5 no underflow end", rdUnderflow, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule